// File: doc/BRIEF.md
# Two-Digit Card Entry Controller

This block assembles a blackjack hand from decoded keypad events and hands it to a downstream strategy block. A card is keyed as two decimal digits. The first digit is confirmed with the player-enter key. The second digit is confirmed with either the player-enter or the dealer-enter key, and that choice decides whose card it is. The block keeps one dealer card and two player registers. When the dealer card and both player registers are filled, in any order, it raises a hand-valid flag and waits for a play code.

Soft hands are handled by moving any ace into the first player register. Every other player card is summed into the second register. If that sum passes ten, the full total is presented instead, with the ace counted as one, and a use-total flag is raised. Play codes clear and reopen registers. A saturating split counter queues split hands so that they are played one after another. A hand-clear key drops the current hand without any other side effect.

Top module: `card_entry_ctrl`

## Requirements
- R1: A card is entered as digit, player-enter, digit, then player-enter (player card) or dealer-enter (dealer card). Its code is ten times the first digit plus the second digit.
- R2: Code 01 is an ace worth 1. Codes 02 to 09 are worth their number. Codes 10 to 13 are worth 10. Any other code, including 00 and 14 or above, is discarded and entry restarts at the first digit.
- R3: A digit key overwrites a digit that has not yet been confirmed. A digit key above 9 is ignored. An enter key with no digit held is ignored. Dealer-enter while a first digit is expected is ignored. If both enter keys arrive on the second digit, player-enter wins.
- R4: `hand_vld` rises in the cycle after the enter that completes the set: one dealer card, the first player register and the second player register. Cards may arrive in any order. A second dealer card, or a player card arriving while both player registers are filled, is discarded.
- R5: When the player holds an ace, `p1_card` reads 1 and `p2_card` reads the sum of the other player cards. A second ace counts 1 in that sum. Without an ace, `p1_card` is the first player card and `p2_card` is the sum of the rest.
- R6: When an ace is held and the remaining sum exceeds 10, `use_total` is 1 and `p2_card` is the full hand total with the ace counted as 1.
- R7: Stand (play code 00) or double (10) with `split_cnt` at 0 clears the dealer card and both player registers, so `hand_vld` is 0 in the next cycle.
- R8: Hit (01) drops `hand_vld` but keeps the dealer card, `p1_card` and the running sum. The next player card is added into the sum, which saturates at 31.
- R9: Split (11) increments `split_cnt`, which saturates at 7. It also clears the second player register and keeps the dealer card and `p1_card`.
- R10: Stand or double with a nonzero `split_cnt` decrements the counter and clears only the second player register. The dealer card and `p1_card` stay.
- R11: The `hand_clr` key clears all card registers, a half-entered card and `split_cnt`. It takes priority over every other input in the same cycle.
- R12: While `hand_vld` is 1, completed cards are discarded. A play code is acted on only while `hand_vld` is 1. If a play code and a completing enter arrive together, the play code is applied and the card is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| digit_vld | input | 1 | Single-cycle digit key event |
| digit_val | input | 4 | Digit value of the key event |
| plyr_enter | input | 1 | Single-cycle player-enter key |
| dlr_enter | input | 1 | Single-cycle dealer-enter key |
| hand_clr | input | 1 | Single-cycle hand-clear key |
| play_vld | input | 1 | Single-cycle play code strobe |
| play_code | input | 2 | 00 stand, 01 hit, 10 double, 11 split |
| hand_vld | output | 1 | Hand complete, presented to strategy |
| dlr_card | output | 4 | Dealer card value 1 to 10 |
| p1_card | output | 4 | First player register (ace when held) |
| p2_card | output | 6 | Second player register sum, or full total |
| use_total | output | 1 | p2_card carries the full total |
| split_cnt | output | 3 | Pending split hands |

## Verification
The bench gives a play code and a card-completing enter in the same cycle. It expects the play code to act while the card disappears, and it checks that by adding a later card and comparing the sum with the value computed arithmetically in the bench. It also gives hand-clear and split together and expects the counter to remain at zero. Around these cases, complete sweeps over dealer and player card codes and over three-card hit sequences compare every presented value with the value the bench computes arithmetically from the card codes.

// File: rtl/card_entry_pkg.sv
package card_entry_pkg;

  localparam logic [1:0] PLAY_STAND  = 2'b00;
  localparam logic [1:0] PLAY_HIT    = 2'b01;
  localparam logic [1:0] PLAY_DOUBLE = 2'b10;
  localparam logic [1:0] PLAY_SPLIT  = 2'b11;

  localparam int unsigned CODE_TOP = 13;
  localparam int unsigned TEN_VAL  = 10;
  localparam int unsigned DIGIT_MAX = 9;

  // Card worth from two entered digits; 0 marks an unusable code.
  function automatic int unsigned code_value(int unsigned hi, int unsigned lo);
    int unsigned code;
    code = hi * 10 + lo;
    if (code >= 1 && code <= 9) return code;
    if (code >= 10 && code <= CODE_TOP) return TEN_VAL;
    return 0;
  endfunction

  // Saturating addition for the running player sum.
  function automatic int unsigned sat_sum(int unsigned a, int unsigned b, int unsigned lim);
    if (a + b > lim) return lim;
    return a + b;
  endfunction

endpackage

// File: rtl/card_key_assembler.sv
module card_key_assembler
  import card_entry_pkg::*;
#(
  parameter int DIG_W = 4,
  parameter int VAL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             digit_vld,
  input  logic [DIG_W-1:0] digit_val,
  input  logic             plyr_enter,
  input  logic             dlr_enter,
  output logic             card_evt,
  output logic             card_dlr,
  output logic [VAL_W-1:0] card_val
);

  logic             second_q;
  logic             held_vld_q;
  logic [DIG_W-1:0] held_q;
  logic [DIG_W-1:0] first_q;

  logic         digit_ok;
  logic         first_take;
  logic         finish;
  int unsigned  code_v;

  assign digit_ok   = digit_vld && (32'(digit_val) <= DIGIT_MAX);
  assign first_take = !second_q && held_vld_q && plyr_enter;
  assign finish     = second_q && held_vld_q && (plyr_enter || dlr_enter);
  assign code_v     = code_value(32'(first_q), 32'(held_q));

  assign card_evt = finish && (code_v != 0);
  assign card_dlr = !plyr_enter;
  assign card_val = VAL_W'(code_v);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      second_q   <= 1'b0;
      held_vld_q <= 1'b0;
      held_q     <= '0;
      first_q    <= '0;
    end else begin
      if (first_take) begin
        first_q  <= held_q;
        second_q <= 1'b1;
      end
      if (finish) second_q <= 1'b0;
      if (digit_ok) begin
        held_q     <= digit_val;
        held_vld_q <= 1'b1;
      end else if (first_take || finish) begin
        held_vld_q <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/card_hand_store.sv
module card_hand_store
  import card_entry_pkg::*;
#(
  parameter int VAL_W = 4,
  parameter int SUM_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             card_evt,
  input  logic             card_dlr,
  input  logic [VAL_W-1:0] card_val,
  input  logic             clr_all,
  input  logic             clr_sum,
  input  logic             hit_open,
  output logic             hand_vld,
  output logic             accept,
  output logic [VAL_W-1:0] dlr_card,
  output logic [VAL_W-1:0] p1_card,
  output logic [SUM_W:0]   p2_card,
  output logic             use_total
);

  localparam int unsigned SUM_MAX = (1 << SUM_W) - 1;
  localparam logic [VAL_W-1:0] ACE = VAL_W'(1);

  logic             dlr_vld_q, r1_vld_q, r2_full_q;
  logic [VAL_W-1:0] dlr_q, r1_q;
  logic [SUM_W-1:0] r2_q;

  logic plyr_acc, dlr_acc, steer_ace;

  assign accept    = card_evt && !hand_vld;
  assign dlr_acc   = accept && card_dlr && !dlr_vld_q;
  assign plyr_acc  = accept && !card_dlr && !(r1_vld_q && r2_full_q);
  assign steer_ace = (card_val == ACE) && (r1_q != ACE);

  always_ff @(posedge clk) begin
    if (!rst_n || clr_all) begin
      dlr_vld_q <= 1'b0;
      r1_vld_q  <= 1'b0;
      r2_full_q <= 1'b0;
      dlr_q     <= '0;
      r1_q      <= '0;
      r2_q      <= '0;
    end else if (clr_sum) begin
      r2_full_q <= 1'b0;
      r2_q      <= '0;
    end else if (hit_open) begin
      r2_full_q <= 1'b0;
    end else begin
      if (dlr_acc) begin
        dlr_vld_q <= 1'b1;
        dlr_q     <= card_val;
      end
      if (plyr_acc) begin
        if (!r1_vld_q) begin
          r1_vld_q <= 1'b1;
          r1_q     <= card_val;
        end else if (steer_ace) begin
          r1_q      <= ACE;
          r2_q      <= SUM_W'(sat_sum(32'(r2_q), 32'(r1_q), SUM_MAX));
          r2_full_q <= 1'b1;
        end else begin
          r2_q      <= SUM_W'(sat_sum(32'(r2_q), 32'(card_val), SUM_MAX));
          r2_full_q <= 1'b1;
        end
      end
    end
  end

  assign hand_vld  = dlr_vld_q && r1_vld_q && r2_full_q;
  assign use_total = r1_vld_q && (r1_q == ACE) && (32'(r2_q) > TEN_VAL);
  assign dlr_card  = dlr_q;
  assign p1_card   = r1_q;
  assign p2_card   = {1'b0, r2_q} + (SUM_W+1)'(use_total);

endmodule

// File: rtl/card_play_seq.sv
module card_play_seq
  import card_entry_pkg::*;
#(
  parameter int SPLIT_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               hand_clr,
  input  logic               play_vld,
  input  logic [1:0]         play_code,
  input  logic               hand_vld,
  output logic               act,
  output logic               clr_all,
  output logic               clr_sum,
  output logic               hit_open,
  output logic [SPLIT_W-1:0] split_cnt
);

  localparam logic [SPLIT_W-1:0] SPLIT_MAX = {SPLIT_W{1'b1}};

  logic [SPLIT_W-1:0] cnt_q;
  logic ends, do_split, pending;

  assign act      = play_vld && hand_vld && !hand_clr;
  assign ends     = act && (play_code == PLAY_STAND || play_code == PLAY_DOUBLE);
  assign do_split = act && (play_code == PLAY_SPLIT);
  assign pending  = (cnt_q != '0);

  assign clr_all  = hand_clr || (ends && !pending);
  assign clr_sum  = do_split || (ends && pending);
  assign hit_open = act && (play_code == PLAY_HIT);

  always_ff @(posedge clk) begin
    if (!rst_n || hand_clr) begin
      cnt_q <= '0;
    end else if (do_split) begin
      if (cnt_q != SPLIT_MAX) cnt_q <= cnt_q + 1'b1;
    end else if (ends && pending) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign split_cnt = cnt_q;

endmodule

// File: rtl/card_entry_ctrl.sv
module card_entry_ctrl
  import card_entry_pkg::*;
#(
  parameter int DIG_W   = 4,
  parameter int VAL_W   = 4,
  parameter int SUM_W   = 5,
  parameter int SPLIT_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               digit_vld,
  input  logic [DIG_W-1:0]   digit_val,
  input  logic               plyr_enter,
  input  logic               dlr_enter,
  input  logic               hand_clr,
  input  logic               play_vld,
  input  logic [1:0]         play_code,
  output logic               hand_vld,
  output logic [VAL_W-1:0]   dlr_card,
  output logic [VAL_W-1:0]   p1_card,
  output logic [SUM_W:0]     p2_card,
  output logic               use_total,
  output logic [SPLIT_W-1:0] split_cnt
);

  logic             card_evt_w, card_dlr_w, accept_w;
  logic [VAL_W-1:0] card_val_w;
  logic             clr_all_w, clr_sum_w, hit_open_w, play_act_w;

  card_key_assembler #(.DIG_W(DIG_W), .VAL_W(VAL_W)) u_keys (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (hand_clr),
    .digit_vld  (digit_vld),
    .digit_val  (digit_val),
    .plyr_enter (plyr_enter),
    .dlr_enter  (dlr_enter),
    .card_evt   (card_evt_w),
    .card_dlr   (card_dlr_w),
    .card_val   (card_val_w)
  );

  card_hand_store #(.VAL_W(VAL_W), .SUM_W(SUM_W)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .card_evt  (card_evt_w),
    .card_dlr  (card_dlr_w),
    .card_val  (card_val_w),
    .clr_all   (clr_all_w),
    .clr_sum   (clr_sum_w),
    .hit_open  (hit_open_w),
    .hand_vld  (hand_vld),
    .accept    (accept_w),
    .dlr_card  (dlr_card),
    .p1_card   (p1_card),
    .p2_card   (p2_card),
    .use_total (use_total)
  );

  card_play_seq #(.SPLIT_W(SPLIT_W)) u_play (
    .clk       (clk),
    .rst_n     (rst_n),
    .hand_clr  (hand_clr),
    .play_vld  (play_vld),
    .play_code (play_code),
    .hand_vld  (hand_vld),
    .act       (play_act_w),
    .clr_all   (clr_all_w),
    .clr_sum   (clr_sum_w),
    .hit_open  (hit_open_w),
    .split_cnt (split_cnt)
  );

endmodule

// File: rtl/card_entry_chk.sv
module card_entry_chk #(
  parameter int VAL_W   = 4,
  parameter int SUM_W   = 5,
  parameter int SPLIT_W = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               hand_clr,
  input logic               play_vld,
  input logic [1:0]         play_code,
  input logic               hand_vld,
  input logic [VAL_W-1:0]   dlr_card,
  input logic [VAL_W-1:0]   p1_card,
  input logic [SUM_W:0]     p2_card,
  input logic               use_total,
  input logic [SPLIT_W-1:0] split_cnt,
  input logic               clr_all,
  input logic               act,
  input logic               accept
);

  localparam logic [SPLIT_W-1:0] SPLIT_TOP = {SPLIT_W{1'b1}};

  // R6
  soft_total_chk: assert property (@(posedge clk) disable iff (!rst_n)
    use_total |-> (p1_card == VAL_W'(1)) && (p2_card > (SUM_W+1)'(11)));

  // R7
  clear_drops_hand_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_all |=> !hand_vld);

  // R8
  hit_keeps_cards_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act && play_code == 2'b01) |=> !hand_vld && $stable(p1_card) && $stable(dlr_card));

  // R9
  split_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act && play_code == 2'b11 && split_cnt != SPLIT_TOP) |=> split_cnt == $past(split_cnt) + 1'b1);

  // R9
  split_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act && play_code == 2'b11 && split_cnt == SPLIT_TOP) |=> split_cnt == SPLIT_TOP);

  // R10
  split_resume_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act && !play_code[0] && split_cnt != '0)
      |=> split_cnt == $past(split_cnt) - 1'b1 && $stable(dlr_card) && $stable(p1_card) && !hand_vld);

  // R11
  hand_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hand_clr |=> split_cnt == '0 && !hand_vld);

  // R12
  valid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hand_vld && !play_vld && !hand_clr) |=> hand_vld && $stable(p2_card) && $stable(dlr_card));

  // R12
  no_accept_when_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hand_vld |-> !accept);

endmodule

bind card_entry_ctrl card_entry_chk #(.VAL_W(VAL_W), .SUM_W(SUM_W), .SPLIT_W(SPLIT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .hand_clr  (hand_clr),
  .play_vld  (play_vld),
  .play_code (play_code),
  .hand_vld  (hand_vld),
  .dlr_card  (dlr_card),
  .p1_card   (p1_card),
  .p2_card   (p2_card),
  .use_total (use_total),
  .split_cnt (split_cnt),
  .clr_all   (clr_all_w),
  .act       (play_act_w),
  .accept    (accept_w)
);

// File: tb/tb_card_entry_ctrl.sv
module tb_card_entry_ctrl;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       digit_vld = 1'b0;
  logic [3:0] digit_val = '0;
  logic       plyr_enter = 1'b0;
  logic       dlr_enter = 1'b0;
  logic       hand_clr = 1'b0;
  logic       play_vld = 1'b0;
  logic [1:0] play_code = '0;
  logic       hand_vld;
  logic [3:0] dlr_card;
  logic [3:0] p1_card;
  logic [5:0] p2_card;
  logic       use_total;
  logic [2:0] split_cnt;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  card_entry_ctrl dut (
    .clk(clk), .rst_n(rst_n), .digit_vld(digit_vld), .digit_val(digit_val),
    .plyr_enter(plyr_enter), .dlr_enter(dlr_enter), .hand_clr(hand_clr),
    .play_vld(play_vld), .play_code(play_code), .hand_vld(hand_vld),
    .dlr_card(dlr_card), .p1_card(p1_card), .p2_card(p2_card),
    .use_total(use_total), .split_cnt(split_cnt)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int cv(input int c);
    return (c >= 10) ? 10 : c;
  endfunction

  task automatic key(input int d);
    @(negedge clk); digit_val = 4'(d); digit_vld = 1'b1;
    @(negedge clk); digit_vld = 1'b0;
  endtask

  task automatic pent();
    @(negedge clk); plyr_enter = 1'b1;
    @(negedge clk); plyr_enter = 1'b0;
  endtask

  task automatic dent();
    @(negedge clk); dlr_enter = 1'b1;
    @(negedge clk); dlr_enter = 1'b0;
  endtask

  task automatic clr();
    @(negedge clk); hand_clr = 1'b1;
    @(negedge clk); hand_clr = 1'b0;
  endtask

  task automatic play(input int code);
    @(negedge clk); play_code = 2'(code); play_vld = 1'b1;
    @(negedge clk); play_vld = 1'b0;
  endtask

  task automatic card(input int code, input bit dlr);
    key(code / 10); pent();
    key(code % 10);
    if (dlr) dent(); else pent();
  endtask

  // Expected presentation computed from the card codes (c == 0: no third card).
  task automatic expect_hand(input string tag, input int d, input int a, input int b, input int c);
    int tot, p2raw, ut, p1;
    bit ace;
    tot   = cv(a) + cv(b) + ((c != 0) ? cv(c) : 0);
    ace   = (a == 1) || (b == 1) || (c == 1);
    p2raw = ace ? tot - 1 : tot - cv(a);
    ut    = (ace && p2raw > 10) ? 1 : 0;
    p1    = ace ? 1 : cv(a);
    check({tag, " R4 hand_vld"}, int'(hand_vld), 1);
    check({tag, " R2 dealer"}, int'(dlr_card), cv(d));
    check({tag, " R5 p1"}, int'(p1_card), p1);
    check({tag, " R5 p2"}, int'(p2_card), ut ? tot : p2raw);
    check({tag, " R6 use_total"}, int'(use_total), ut);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 reset hand_vld", int'(hand_vld), 0);
    check("R11 reset split_cnt", int'(split_cnt), 0);

    // R1 R4 R5: sweep dealer and two player codes, dealer position rotating
    for (int d = 1; d <= 13; d++)
      for (int a = 1; a <= 13; a++)
        for (int b = 1; b <= 13; b++) begin
          int pos;
          pos = (d + a + b) % 3;
          if (pos == 0) card(d, 1'b1);
          card(a, 1'b0);
          if (pos == 1) card(d, 1'b1);
          card(b, 1'b0);
          if (pos == 2) card(d, 1'b1);
          expect_hand("sweep", d, a, b, 0);
          play(((a + b) % 2 == 0) ? 0 : 2);
          check("R7 stand/double clears", int'(hand_vld), 0);
        end

    // R8 R6: hit sweep with a third card, ace steering in any position
    for (int a = 1; a <= 10; a++)
      for (int b = 1; b <= 10; b++)
        for (int c = 1; c <= 10; c++) begin
          int d;
          d = (a + b + c) % 13 + 1;
          card(d, 1'b1); card(a, 1'b0); card(b, 1'b0);
          play(1);
          check("R8 hit drops hand_vld", int'(hand_vld), 0);
          card(c, 1'b0);
          expect_hand("R8 hit", d, a, b, c);
          play(0);
        end

    // R3: overwrite, stray enters, digit above 9, dealer-enter on first digit
    key(4); key(0); pent();
    pent();
    key(7); dent();
    key(0); dent(); pent();
    key(3); key(12); pent();
    card(5, 1'b0);
    check("R3 dealer after overwrite", int'(dlr_card), 7);
    check("R3 p1 code 03", int'(p1_card), 3);
    check("R3 p2", int'(p2_card), 5);
    check("R3 hand_vld", int'(hand_vld), 1);
    play(0);

    // R2: unusable codes discarded
    card(14, 1'b1); card(0, 1'b1);
    card(2, 1'b0); card(3, 1'b0);
    check("R2 bad dealer codes dropped", int'(hand_vld), 0);
    card(11, 1'b1);
    expect_hand("R2 jack", 11, 2, 3, 0);

    // R12: extra cards while valid are dropped
    card(9, 1'b0); card(4, 1'b1);
    expect_hand("R12 extra cards", 11, 2, 3, 0);
    play(0);
    card(6, 1'b0);
    play(3);
    check("R12 play ignored when not valid", int'(split_cnt), 0);
    clr();

    // R12: play code and completing enter in the same cycle
    card(6, 1'b1); card(5, 1'b0); card(2, 1'b0);
    key(0); pent(); key(9);
    @(negedge clk); plyr_enter = 1'b1; play_code = 2'b01; play_vld = 1'b1;
    @(negedge clk); plyr_enter = 1'b0; play_vld = 1'b0;
    check("R12 hit wins, card dropped", int'(hand_vld), 0);
    card(4, 1'b0);
    expect_hand("R12 after collision", 6, 5, 2, 4);
    // R11: hand clear together with split
    @(negedge clk); hand_clr = 1'b1; play_code = 2'b11; play_vld = 1'b1;
    @(negedge clk); hand_clr = 1'b0; play_vld = 1'b0;
    check("R11 clear beats split cnt", int'(split_cnt), 0);
    check("R11 clear beats split vld", int'(hand_vld), 0);

    // R9 R10 R7: split replay
    card(6, 1'b1); card(8, 1'b0); card(8, 1'b0);
    play(3);
    check("R9 split count", int'(split_cnt), 1);
    check("R9 split reopens", int'(hand_vld), 0);
    card(3, 1'b0);
    check("R9 split p1", int'(p1_card), 8);
    check("R9 split p2", int'(p2_card), 3);
    play(0);
    check("R10 stand decrements", int'(split_cnt), 0);
    check("R10 stand reopens", int'(hand_vld), 0);
    card(10, 1'b0);
    check("R10 dealer kept", int'(dlr_card), 6);
    check("R10 p1 kept", int'(p1_card), 8);
    check("R10 p2 new", int'(p2_card), 10);
    check("R10 valid again", int'(hand_vld), 1);
    play(0);
    card(2, 1'b0); card(3, 1'b0);
    check("R7 dealer cleared", int'(hand_vld), 0);
    clr();

    // R9 saturation, R10 double decrement, R11 clear of counter
    card(6, 1'b1); card(8, 1'b0); card(8, 1'b0);
    for (int i = 1; i <= 9; i++) begin
      play(3);
      check("R9 saturating count", int'(split_cnt), (i > 7) ? 7 : i);
      card(8, 1'b0);
    end
    play(2);
    check("R10 double decrements", int'(split_cnt), 6);
    card(1, 1'b0);
    check("R10 ace into sum p1", int'(p1_card), 1);
    check("R10 ace into sum p2", int'(p2_card), 8);
    clr();
    check("R11 clear counter", int'(split_cnt), 0);

    // R11: half-entered card discarded
    key(1); pent(); clr();
    card(3, 1'b1); card(2, 1'b0); card(9, 1'b0);
    expect_hand("R11 partial dropped", 3, 2, 9, 0);
    play(0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule